// File: doc/BRIEF.md
# Misaligned Fetch Group Aligner

This block returns a group of consecutive instructions in one cycle from an instruction store built as rows of column banks. The fetch address is an instruction index split into a tag, a row index and a column offset. The group starts at the column the offset names. It can run past the end of that row into the next row.

Each column bank works out its own row address. A bank whose column lies before the offset reads the following row, and every other bank reads the addressed row, so a group that crosses a row boundary is still read in a single access. The bank outputs pass through a rotator that puts the first instruction of the group in slot 0. A per-slot valid mask reports, for each slot, whether its row holds the tag the slot's address expects. A hit flag is raised when every slot is valid. A whole-row write port loads contents.

Top module: `fetch_aligner`

## Requirements
- R1: The fetch address `req_pc` is an instruction index laid out as {tag, row, offset}. The offset is the low log2(NCOL) bits, the row is the next ROW_AW bits and the tag is the top TAG_W bits. Output slot s holds the instruction at address `req_pc + s`.
- R2: Column bank c reads row `row + 1` when the offset is greater than c. Otherwise it reads row `row`.
- R3: A lookup issued with `req_valid` high at a clock edge has its results on the outputs after that edge, with `out_valid` high. A cycle with `req_valid` low is followed by `out_valid` low. `out_valid` is 0 out of reset.
- R4: Slot 0 carries the instruction in column `offset` of the addressed row. The remaining slots follow in increasing address order.
- R5: `out_mask[s]` is 1 exactly when the row holding address `req_pc + s` has been written since reset with a tag equal to that address's tag field. `out_hit` is 1 exactly when all mask bits are 1.
- R6: When the row index is all ones, columns that take the next row read row 0, and their expected tag is the fetch tag plus one, modulo 2^TAG_W.
- R7: A write with `wr_en` high stores `wr_line` into row `wr_row`, with bits [c*IW +: IW] going to column c. It also records `wr_tag` for that row and marks the row valid.
- R8: Synchronous reset marks every row invalid, so a lookup after reset returns an all-zero mask and `out_hit` 0.
- R9: When a write and a lookup touch the same row in the same cycle, the lookup returns the contents from before the write. The new contents are seen by the next lookup.
- R10: `out_mask` and `out_hit` are 0 whenever `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Row write strobe |
| wr_row | input | ROW_AW | Row to write |
| wr_tag | input | TAG_W | Tag recorded for the written row |
| wr_line | input | NCOL*IW | Row contents, column c in bits [c*IW +: IW] |
| req_valid | input | 1 | Lookup request |
| req_pc | input | TAG_W+ROW_AW+log2(NCOL) | Fetch instruction index |
| out_valid | output | 1 | Lookup result present |
| out_instr | output | NCOL*IW | Aligned group, slot s in bits [s*IW +: IW] |
| out_mask | output | NCOL | Per-slot tag-match valid |
| out_hit | output | 1 | All slots valid |

## Verification
A row write and a lookup can fall in the same cycle, so a row can be rewritten while a group is being read from it. The bench provokes this directly by writing the row a lookup addresses, and also the row its crossing columns take. Random traffic also overlaps writes with lookups. A reference model is updated only after each lookup's expected values are taken. The old contents must therefore come out in that cycle, and the new contents on the following lookup.

// File: rtl/fa_pkg.sv
package fa_pkg;

    localparam int unsigned FA_NCOL   = 4;
    localparam int unsigned FA_IW     = 32;
    localparam int unsigned FA_ROW_AW = 3;
    localparam int unsigned FA_TAG_W  = 8;

    // Source column for an output slot: offset plus slot, modulo column count.
    function automatic int unsigned fa_slot_col(input int unsigned off,
                                                input int unsigned slot,
                                                input int unsigned ncol);
        return (off + slot) % ncol;
    endfunction

    // A column takes the next row when the group starts beyond it.
    function automatic logic fa_takes_next(input int unsigned off,
                                           input int unsigned col);
        return off > col;
    endfunction

endpackage

// File: rtl/fa_row_sel.sv
module fa_row_sel #(
    parameter int unsigned NCOL   = 4,
    parameter int unsigned ROW_AW = 3,
    parameter int unsigned TAG_W  = 8,
    localparam int unsigned OFF_W = $clog2(NCOL)
) (
    input  logic [TAG_W-1:0]                 pc_tag,
    input  logic [ROW_AW-1:0]                pc_row,
    input  logic [OFF_W-1:0]                 pc_off,
    output logic [NCOL-1:0][ROW_AW-1:0]      col_row,
    output logic [NCOL-1:0][TAG_W-1:0]       col_tag,
    output logic [NCOL-1:0]                  col_next
);
    logic [ROW_AW-1:0] row_inc;
    logic [TAG_W-1:0]  tag_inc;
    logic              row_last;

    always_comb begin
        row_inc  = pc_row + 1'b1;
        tag_inc  = pc_tag + 1'b1;
        row_last = &pc_row;
    end

    for (genvar c = 0; c < NCOL; c++) begin : g_col
        always_comb begin
            col_next[c] = fa_pkg::fa_takes_next(int'(pc_off), c);
            col_row[c]  = col_next[c] ? row_inc : pc_row;
            col_tag[c]  = (col_next[c] && row_last) ? tag_inc : pc_tag;
        end

        if (c > 0) begin : g_order
            // A column that takes the next row implies every lower one does.
            always_comb begin
                AST_SEL_ORDER: assert (!col_next[c] || col_next[c-1]); // R2
            end
        end
    end

endmodule

// File: rtl/fa_bank.sv
module fa_bank #(
    parameter int unsigned ROW_AW = 3,
    parameter int unsigned IW     = 32,
    parameter int unsigned TAG_W  = 8,
    localparam int unsigned ROWS  = 1 << ROW_AW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ROW_AW-1:0] wr_row,
    input  logic [IW-1:0]     wr_instr,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic              rd_en,
    input  logic [ROW_AW-1:0] rd_row,
    output logic [IW-1:0]     rd_instr,
    output logic [TAG_W-1:0]  rd_tag,
    output logic              rd_vld
);
    logic [IW-1:0]    mem_instr [ROWS];
    logic [TAG_W-1:0] mem_tag   [ROWS];
    logic [ROWS-1:0]  mem_vld;

    // Read-first: the read register takes the pre-write contents.
    always_ff @(posedge clk) begin
        if (rd_en) begin
            rd_instr <= mem_instr[rd_row];
            rd_tag   <= mem_tag[rd_row];
        end
        if (wr_en) begin
            mem_instr[wr_row] <= wr_instr;
            mem_tag[wr_row]   <= wr_tag;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_vld <= '0;
            rd_vld  <= 1'b0;
        end else begin
            if (rd_en) rd_vld <= mem_vld[rd_row];
            if (wr_en) mem_vld[wr_row] <= 1'b1;
        end
    end

    AST_WR_SETS_VLD: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> mem_vld[$past(wr_row)]); // R7

endmodule

// File: rtl/fa_rotator.sv
module fa_rotator #(
    parameter int unsigned NCOL  = 4,
    parameter int unsigned IW    = 32,
    parameter int unsigned TAG_W = 8,
    localparam int unsigned OFF_W = $clog2(NCOL)
) (
    input  logic                        grp_vld,
    input  logic [OFF_W-1:0]            grp_off,
    input  logic [NCOL-1:0][IW-1:0]     bank_instr,
    input  logic [NCOL-1:0][TAG_W-1:0]  bank_tag,
    input  logic [NCOL-1:0]             bank_vld,
    input  logic [NCOL-1:0][TAG_W-1:0]  exp_tag,
    output logic [NCOL-1:0][IW-1:0]     slot_instr,
    output logic [NCOL-1:0]             slot_mask
);
    logic [NCOL-1:0] col_match;

    for (genvar c = 0; c < NCOL; c++) begin : g_cmp
        always_comb col_match[c] = bank_vld[c] && (bank_tag[c] == exp_tag[c]);
    end

    for (genvar s = 0; s < NCOL; s++) begin : g_slot
        always_comb begin
            int unsigned src;
            src           = fa_pkg::fa_slot_col(int'(grp_off), s, NCOL);
            slot_instr[s] = bank_instr[src];
            slot_mask[s]  = grp_vld && col_match[src];
        end
    end

endmodule

// File: rtl/fetch_aligner.sv
module fetch_aligner #(
    parameter int unsigned NCOL   = fa_pkg::FA_NCOL,
    parameter int unsigned IW     = fa_pkg::FA_IW,
    parameter int unsigned ROW_AW = fa_pkg::FA_ROW_AW,
    parameter int unsigned TAG_W  = fa_pkg::FA_TAG_W,
    localparam int unsigned OFF_W = $clog2(NCOL),
    localparam int unsigned PC_W  = TAG_W + ROW_AW + OFF_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [ROW_AW-1:0]    wr_row,
    input  logic [TAG_W-1:0]     wr_tag,
    input  logic [NCOL*IW-1:0]   wr_line,
    input  logic                 req_valid,
    input  logic [PC_W-1:0]      req_pc,
    output logic                 out_valid,
    output logic [NCOL*IW-1:0]   out_instr,
    output logic [NCOL-1:0]      out_mask,
    output logic                 out_hit
);
    logic [TAG_W-1:0]  pc_tag;
    logic [ROW_AW-1:0] pc_row;
    logic [OFF_W-1:0]  pc_off;

    always_comb begin
        pc_off = req_pc[OFF_W-1:0];
        pc_row = req_pc[OFF_W +: ROW_AW];
        pc_tag = req_pc[PC_W-1 -: TAG_W];
    end

    logic [NCOL-1:0][ROW_AW-1:0] col_row;
    logic [NCOL-1:0][TAG_W-1:0]  col_tag;
    logic [NCOL-1:0]             col_next;

    fa_row_sel #(.NCOL(NCOL), .ROW_AW(ROW_AW), .TAG_W(TAG_W)) u_row_sel (
        .pc_tag   (pc_tag),
        .pc_row   (pc_row),
        .pc_off   (pc_off),
        .col_row  (col_row),
        .col_tag  (col_tag),
        .col_next (col_next)
    );

    logic [NCOL-1:0][IW-1:0]    bank_instr;
    logic [NCOL-1:0][TAG_W-1:0] bank_tag;
    logic [NCOL-1:0]            bank_vld;

    for (genvar c = 0; c < NCOL; c++) begin : g_bank
        fa_bank #(.ROW_AW(ROW_AW), .IW(IW), .TAG_W(TAG_W)) u_bank (
            .clk      (clk),
            .rst      (rst),
            .wr_en    (wr_en),
            .wr_row   (wr_row),
            .wr_instr (wr_line[c*IW +: IW]),
            .wr_tag   (wr_tag),
            .rd_en    (req_valid),
            .rd_row   (col_row[c]),
            .rd_instr (bank_instr[c]),
            .rd_tag   (bank_tag[c]),
            .rd_vld   (bank_vld[c])
        );
    end

    // Lookup stage: offset and expected tags travel with the bank reads.
    logic                        s1_valid;
    logic [OFF_W-1:0]            s1_off;
    logic [NCOL-1:0][TAG_W-1:0]  s1_exp_tag;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid   <= 1'b0;
            s1_off     <= '0;
            s1_exp_tag <= '0;
        end else begin
            s1_valid <= req_valid;
            if (req_valid) begin
                s1_off     <= pc_off;
                s1_exp_tag <= col_tag;
            end
        end
    end

    logic [NCOL-1:0][IW-1:0] slot_instr;
    logic [NCOL-1:0]         slot_mask;

    fa_rotator #(.NCOL(NCOL), .IW(IW), .TAG_W(TAG_W)) u_rot (
        .grp_vld    (s1_valid),
        .grp_off    (s1_off),
        .bank_instr (bank_instr),
        .bank_tag   (bank_tag),
        .bank_vld   (bank_vld),
        .exp_tag    (s1_exp_tag),
        .slot_instr (slot_instr),
        .slot_mask  (slot_mask)
    );

    always_comb begin
        out_valid = s1_valid;
        out_instr = slot_instr;
        out_mask  = slot_mask;
        out_hit   = &slot_mask;
    end

    AST_REQ_TO_OUT: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> out_valid); // R3
    AST_IDLE_TO_OUT: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !out_valid); // R3
    AST_MASK_GATED: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (out_mask == '0 && !out_hit)); // R10

endmodule

// File: tb/fetch_aligner_tb.sv
module fetch_aligner_tb;
    localparam int NCOL = 4, IW = 32, ROW_AW = 3, TAG_W = 8;
    localparam int OFF_W = 2, PC_W = TAG_W + ROW_AW + OFF_W, ROWS = 8;

    logic clk = 1'b0, rst = 1'b1;
    logic wr_en = 1'b0, req_valid = 1'b0;
    logic [ROW_AW-1:0] wr_row = '0;
    logic [TAG_W-1:0] wr_tag = '0;
    logic [NCOL*IW-1:0] wr_line = '0;
    logic [PC_W-1:0] req_pc = '0;
    logic out_valid, out_hit;
    logic [NCOL*IW-1:0] out_instr;
    logic [NCOL-1:0] out_mask;

    fetch_aligner u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_row(wr_row), .wr_tag(wr_tag),
        .wr_line(wr_line), .req_valid(req_valid), .req_pc(req_pc),
        .out_valid(out_valid), .out_instr(out_instr), .out_mask(out_mask),
        .out_hit(out_hit)
    );

    always #2 clk = ~clk;

    int checks = 0, errors = 0;
    bit finished = 0;
    logic [IW-1:0]    m_data [ROWS][NCOL];
    logic [TAG_W-1:0] m_tag  [ROWS];
    bit               m_vld  [ROWS];

    task automatic chk(input bit ok, input string req, input logic [IW-1:0] act,
                       input logic [IW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [NCOL-1:0] exp_mask(input logic [PC_W-1:0] pc);
        logic [NCOL-1:0] m;
        for (int s = 0; s < NCOL; s++) begin
            logic [PC_W-1:0] a;
            logic [ROW_AW-1:0] r;
            a = pc + PC_W'(s);
            r = a[OFF_W +: ROW_AW];
            m[s] = m_vld[r] && (m_tag[r] == a[PC_W-1 -: TAG_W]);
        end
        return m;
    endfunction

    function automatic logic [IW-1:0] exp_instr(input logic [PC_W-1:0] pc, input int s);
        logic [PC_W-1:0] a;
        a = pc + PC_W'(s);
        return m_data[a[OFF_W +: ROW_AW]][a[OFF_W-1:0]];
    endfunction

    task automatic do_write(input logic [ROW_AW-1:0] r, input logic [TAG_W-1:0] t,
                            input logic [NCOL*IW-1:0] line);
        @(negedge clk);
        wr_en = 1'b1; wr_row = r; wr_tag = t; wr_line = line;
        @(negedge clk);
        wr_en = 1'b0;
        for (int c = 0; c < NCOL; c++) m_data[r][c] = line[c*IW +: IW];
        m_tag[r] = t; m_vld[r] = 1'b1;
    endtask

    // Lookup with an optional write in the same cycle; model updated afterwards.
    task automatic lookup(input logic [PC_W-1:0] pc, input bit cmp_data, input string req,
                          input bit w, input logic [ROW_AW-1:0] r, input logic [TAG_W-1:0] t,
                          input logic [NCOL*IW-1:0] line);
        logic [NCOL-1:0] em;
        logic [IW-1:0] ei [NCOL];
        @(negedge clk);
        req_valid = 1'b1; req_pc = pc;
        wr_en = w; wr_row = r; wr_tag = t; wr_line = line;
        em = exp_mask(pc);
        for (int s = 0; s < NCOL; s++) ei[s] = exp_instr(pc, s);
        @(negedge clk);
        req_valid = 1'b0; wr_en = 1'b0;
        chk(out_valid == 1'b1, {req, " R3 valid"}, IW'(out_valid), 1);
        chk(out_mask == em, {req, " R5 mask"}, IW'(out_mask), IW'(em));
        chk(out_hit == (&em), {req, " R5 hit"}, IW'(out_hit), IW'(&em));
        if (cmp_data)
            for (int s = 0; s < NCOL; s++)
                chk(out_instr[s*IW +: IW] == ei[s], {req, " R1 slot"},
                    out_instr[s*IW +: IW], ei[s]);
        if (w) begin
            for (int c = 0; c < NCOL; c++) m_data[r][c] = line[c*IW +: IW];
            m_tag[r] = t; m_vld[r] = 1'b1;
        end
    endtask

    function automatic logic [NCOL*IW-1:0] rnd_line();
        logic [NCOL*IW-1:0] l;
        for (int c = 0; c < NCOL; c++) l[c*IW +: IW] = $urandom();
        return l;
    endfunction

    function automatic logic [PC_W-1:0] mk_pc(input int t, input int r, input int o);
        return {TAG_W'(t), ROW_AW'(r), OFF_W'(o)};
    endfunction

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd2718));
        for (int r = 0; r < ROWS; r++) m_vld[r] = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R3 / R10: idle after reset
        chk(out_valid == 1'b0, "R3 reset valid", IW'(out_valid), 0);
        chk(out_mask == '0 && !out_hit, "R10 idle mask", IW'(out_mask), 0);
        // R8: lookup after reset finds nothing valid
        lookup(mk_pc(0, 0, 0), 1'b0, "R8 post-reset", 1'b0, '0, '0, '0);

        // R7: preload all rows; row 7 tag 5, row 0 tag 6 for the wrap case
        for (int r = 0; r < ROWS; r++)
            do_write(ROW_AW'(r), (r == 0) ? 8'd6 : 8'd5, rnd_line());

        // R4 aligned group, R2 crossing group, R1 every offset
        lookup(mk_pc(5, 2, 0), 1'b1, "R4 aligned", 1'b0, '0, '0, '0);
        lookup(mk_pc(5, 2, 2), 1'b1, "R2 offset2", 1'b0, '0, '0, '0);
        lookup(mk_pc(5, 3, 1), 1'b1, "R1 offset1", 1'b0, '0, '0, '0);
        lookup(mk_pc(5, 4, 3), 1'b1, "R1 offset3", 1'b0, '0, '0, '0);
        // R6: last row crossing into row 0 with tag plus one
        lookup(mk_pc(5, 7, 3), 1'b1, "R6 wrap hit", 1'b0, '0, '0, '0);
        lookup(mk_pc(5, 7, 0), 1'b1, "R6 wrap none", 1'b0, '0, '0, '0);
        // R5: partial mismatch (row 1 tag 5, row 0 tag 6)
        lookup(mk_pc(6, 0, 2), 1'b1, "R5 partial", 1'b0, '0, '0, '0);
        lookup(mk_pc(9, 3, 0), 1'b1, "R5 miss", 1'b0, '0, '0, '0);
        // R10: idle cycle after a lookup
        @(negedge clk);
        chk(out_valid == 1'b0, "R10 idle valid", IW'(out_valid), 0);
        chk(out_mask == '0 && !out_hit, "R10 idle mask", IW'(out_mask), 0);
        // R9: write the addressed row and the next row during lookup
        lookup(mk_pc(5, 4, 2), 1'b1, "R9 same row", 1'b1, 3'd4, 8'd5, rnd_line());
        lookup(mk_pc(5, 4, 2), 1'b1, "R9 after", 1'b0, '0, '0, '0);
        lookup(mk_pc(5, 4, 2), 1'b1, "R9 next row", 1'b1, 3'd5, 8'd7, rnd_line());
        lookup(mk_pc(5, 4, 2), 1'b1, "R9 after2", 1'b0, '0, '0, '0);

        // Random traffic over a small tag set, writes overlapping lookups
        for (int i = 0; i < 400; i++) begin
            bit w;
            w = ($urandom() % 4) == 0;
            lookup(mk_pc(4 + $urandom() % 3, $urandom() % ROWS, $urandom() % NCOL),
                   1'b1, "R1 random", w, ROW_AW'($urandom()),
                   TAG_W'(4 + $urandom() % 3), rnd_line());
        end

        // R8: reset again clears every row
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        for (int r = 0; r < ROWS; r++) m_vld[r] = 1'b0;
        lookup(mk_pc(5, 2, 1), 1'b0, "R8 re-reset", 1'b0, '0, '0, '0);
        finish_run();
    end
endmodule